// File: doc/BRIEF.md
# Decode-Stage Interlock for a Five-Stage Pipeline

This block decides each cycle whether the instruction held in the decode register may advance. It watches the source registers of the decoding instruction and the destinations of the two instructions ahead of it, in the execute and memory stages. From these it produces three controls: a write-enable for the program counter, a write-enable for the fetch/decode register, and a bubble request. The bubble request clears the control fields that enter the execute stage.

Two kinds of dependence cause a stall. The first is an ordinary consumer that needs the result of a load that has not yet read memory. The second is a branch, which compares its registers in decode and so needs its operands one stage earlier than an ALU consumer would. For a branch, the unit stalls for one or two cycles depending on what kind of instruction produces the operand and how far ahead of the branch it is.

The unit is purely combinational. A two-cycle stall is not counted anywhere. It happens because the condition is checked again on the following cycle, once the load has moved on to the memory stage. The clock and reset inputs feed only the embedded checks.

Top module: `hzd_interlock`

## Requirements
- R1: When the execute-stage instruction has its memory-read flag set, and its non-zero destination equals either decode source register, the unit stalls. This applies whether or not the decoding instruction is a branch.
- R2: A stall drives bubble_o=1, pc_we_o=0 and ifid_we_o=0. With no stall, the unit drives bubble_o=0, pc_we_o=1 and ifid_we_o=1.
- R3: A decode branch stalls when the execute-stage instruction writes a register, has its memory-read flag clear, and has a non-zero destination equal to either branch source.
- R4: A decode branch stalls when the memory-stage instruction has its memory-read flag set and a non-zero destination equal to either branch source.
- R5: A branch directly behind a load to one of its sources stalls in two consecutive cycles: first with the load in execute, then with the load in memory. It does not stall in the third cycle.
- R6: A branch whose source is produced by a memory-stage instruction with its memory-read flag clear does not stall.
- R7: A destination of register 0 never causes a stall, in either stage.
- R8: A non-branch instruction does not stall on an execute-stage ALU producer, and does not stall on a memory-stage load.
- R9: An execute-stage instruction that neither writes a register nor reads memory causes no stall.
- R10: All three outputs follow the inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used only by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset, used only by the embedded checks |
| id_rs_i | input | REG_W | First source register of the decoding instruction |
| id_rt_i | input | REG_W | Second source register of the decoding instruction |
| id_branch_i | input | 1 | The decoding instruction is a compare-in-decode branch |
| ex_dst_i | input | REG_W | Destination register of the execute-stage instruction |
| ex_mem_read_i | input | 1 | The execute-stage instruction is a load |
| ex_reg_write_i | input | 1 | The execute-stage instruction writes a register |
| mem_dst_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_mem_read_i | input | 1 | The memory-stage instruction is a load |
| pc_we_o | output | 1 | Program counter may update |
| ifid_we_o | output | 1 | Fetch/decode register may update |
| bubble_o | output | 1 | Clear the control fields entering the execute stage |

## Verification
The load-use check and the branch check can fire in the same cycle. This happens when a load sits in execute and the instruction behind it is a branch that reads the load's destination. It can also happen when a second load, two places ahead, feeds the other branch operand. The exhaustive sweep covers every combination of flags and register numbers in a two-bit register space, so both overlaps occur many times. In each case the bench requires a single, ordinary stall, not a conflicting or doubled response. A directed three-cycle sequence then walks one load past one branch and confirms the stall lasts exactly two cycles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_LDUSE  = 2'd1,
    CAUSE_BR_EX  = 2'd2,
    CAUSE_BR_MEM = 2'd3
  } stall_cause_e;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            en_i,
  input  logic [REG_W-1:0]                dst_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   src_i,
  output logic                            hit_o
);
  logic [NUM_SRC-1:0] eq;
  logic               dst_live;

  // register 0 is hard-wired, never a real producer
  assign dst_live = (dst_i != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign eq[g] = (src_i[g] == dst_i);
  end

  assign hit_o = en_i && dst_live && (|eq);
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
  input  logic [REG_W-1:0]              ex_dst_i,
  input  logic                          ex_mem_read_i,
  output logic                          hit_o
);
  hzd_src_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_match (
    .en_i  (ex_mem_read_i),
    .dst_i (ex_dst_i),
    .src_i (src_i),
    .hit_o (hit_o)
  );
endmodule

// File: rtl/hzd_branch_chk.sv
module hzd_branch_chk #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                          branch_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
  input  logic [REG_W-1:0]              ex_dst_i,
  input  logic                          ex_mem_read_i,
  input  logic                          ex_reg_write_i,
  input  logic [REG_W-1:0]              mem_dst_i,
  input  logic                          mem_mem_read_i,
  output logic                          ex_hit_o,
  output logic                          mem_hit_o
);
  logic ex_en, mem_en;

  // any producer in EX is too late for a decode compare
  assign ex_en  = branch_i && (ex_reg_write_i || ex_mem_read_i);
  // only a load in MEM is too late; ALU results forward from EX/MEM
  assign mem_en = branch_i && mem_mem_read_i;

  hzd_src_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_ex_match (
    .en_i  (ex_en),
    .dst_i (ex_dst_i),
    .src_i (src_i),
    .hit_o (ex_hit_o)
  );

  hzd_src_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_mem_match (
    .en_i  (mem_en),
    .dst_i (mem_dst_i),
    .src_i (src_i),
    .hit_o (mem_hit_o)
  );
endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_pkg::*;
(
  input  logic         lduse_i,
  input  logic         br_ex_i,
  input  logic         br_mem_i,
  output stall_cause_e cause_o,
  output logic         pc_we_o,
  output logic         ifid_we_o,
  output logic         bubble_o
);
  always_comb begin
    if (lduse_i)       cause_o = CAUSE_LDUSE;
    else if (br_ex_i)  cause_o = CAUSE_BR_EX;
    else if (br_mem_i) cause_o = CAUSE_BR_MEM;
    else               cause_o = CAUSE_NONE;
  end

  assign bubble_o  = (cause_o != CAUSE_NONE);
  assign pc_we_o   = (cause_o == CAUSE_NONE);
  assign ifid_we_o = (cause_o == CAUSE_NONE);
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             ex_mem_read_i,
  input  logic             ex_reg_write_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_mem_read_i,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o
);
  logic [NUM_SRC-1:0][REG_W-1:0] srcs;
  logic                          lduse_hit, br_ex_hit, br_mem_hit;
  stall_cause_e                  cause;

  assign srcs = {id_rt_i, id_rs_i};

  hzd_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_load_use (
    .src_i         (srcs),
    .ex_dst_i      (ex_dst_i),
    .ex_mem_read_i (ex_mem_read_i),
    .hit_o         (lduse_hit)
  );

  hzd_branch_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_branch_chk (
    .branch_i       (id_branch_i),
    .src_i          (srcs),
    .ex_dst_i       (ex_dst_i),
    .ex_mem_read_i  (ex_mem_read_i),
    .ex_reg_write_i (ex_reg_write_i),
    .mem_dst_i      (mem_dst_i),
    .mem_mem_read_i (mem_mem_read_i),
    .ex_hit_o       (br_ex_hit),
    .mem_hit_o      (br_mem_hit)
  );

  hzd_stall_ctrl u_stall_ctrl (
    .lduse_i   (lduse_hit),
    .br_ex_i   (br_ex_hit),
    .br_mem_i  (br_mem_hit),
    .cause_o   (cause),
    .pc_we_o   (pc_we_o),
    .ifid_we_o (ifid_we_o),
    .bubble_o  (bubble_o)
  );

  AST_LDUSE_BUBBLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lduse_hit |-> (bubble_o && !pc_we_o)); // R1
  AST_HOLD_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o == ifid_we_o) && (bubble_o != pc_we_o)); // R2
  AST_BR_EX_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_ex_hit |-> !ifid_we_o); // R3
  AST_BR_MEM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_mem_hit |-> !ifid_we_o); // R4
  AST_ZERO_DST_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dst_i == '0 && mem_dst_i == '0) |-> !bubble_o); // R7
  AST_IDLE_EX_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_mem_read_i && !ex_reg_write_i && !mem_mem_read_i) |-> !bubble_o); // R9
  AST_NONBR_ALU_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_branch_i && !ex_mem_read_i) |-> pc_we_o); // R8
endmodule

// File: tb/hzd_interlock_tb.sv
module hzd_interlock_tb;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] rs, rt, exd, memd;
  logic br, exwe, exmr, memmr;
  logic pc_we, ifid_we, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hzd_interlock #(.REG_W(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs_i(rs), .id_rt_i(rt), .id_branch_i(br),
    .ex_dst_i(exd), .ex_mem_read_i(exmr), .ex_reg_write_i(exwe),
    .mem_dst_i(memd), .mem_mem_read_i(memmr),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble)
  );

  task automatic check(input string tag, input logic exp_stall);
    logic [2:0] act, exp;
    act = {pc_we, ifid_we, bubble};
    exp = {~exp_stall, ~exp_stall, exp_stall};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pc_we,ifid_we,bubble}=%b expected %b (rs=%0d rt=%0d br=%b exd=%0d exwe=%b exmr=%b memd=%0d memmr=%b)",
               tag, act, exp, rs, rt, br, exd, exwe, exmr, memd, memmr);
    end
  endtask

  task automatic drive(input int v);
    @(negedge clk);
    rs = v[1:0]; rt = v[3:2]; exd = v[5:4]; memd = v[7:6];
    br = v[8]; exwe = v[9]; exmr = v[10]; memmr = v[11];
    #1;
  endtask

  initial begin
    rs = '0; rt = '0; exd = '0; memd = '0;
    br = 0; exwe = 0; exmr = 0; memmr = 0;
    #1;
    check("R2 reset idle", 1'b0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R10: every combination, sampled 1 ns after the inputs change
    for (int v = 0; v < 4096; v++) begin
      logic exhit, memhit, lu, bex, bmem;
      string tag;
      drive(v);
      exhit  = (exd != 0) && (exd == rs || exd == rt);
      memhit = (memd != 0) && (memd == rs || memd == rt);
      lu   = exmr && exhit;
      bex  = br && (exwe || exmr) && exhit;
      bmem = br && memmr && memhit;
      if (lu)                              tag = "R1 load-use";
      else if (bex)                        tag = "R3 branch ALU in EX";
      else if (bmem)                       tag = "R4 branch load in MEM";
      else if (exd == 0 && memd == 0)      tag = "R7 zero dst";
      else if (!exwe && !exmr)             tag = "R9 idle EX";
      else if (br && memhit && !memmr)     tag = "R6 branch ALU in MEM";
      else if (!br)                        tag = "R8 non-branch";
      else                                 tag = "R2 no stall";
      check(tag, lu | bex | bmem);
    end

    // R5: load then dependent branch, stepped through three cycles
    @(negedge clk);
    rs = 2'd1; rt = 2'd3; br = 1;
    exd = 2'd1; exmr = 1; exwe = 1; memd = 2'd0; memmr = 0; #1;
    check("R5 cycle1 load in EX", 1'b1);
    @(negedge clk);
    exd = 2'd0; exmr = 0; exwe = 0; memd = 2'd1; memmr = 1; #1;
    check("R5 cycle2 load in MEM", 1'b1);
    @(negedge clk);
    memd = 2'd0; memmr = 0; #1;
    check("R5 cycle3 released", 1'b0);

    // R6: ALU two ahead of a branch forwards
    @(negedge clk);
    memd = 2'd3; memmr = 0; #1;
    check("R6 ALU in MEM", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule